// File: doc/BRIEF.md
# Optical Link Integrity Monitor

This block decides whether a fiber receive link is usable. It watches three things: a flag from an external level comparator that says the received optical power is above threshold, the sliced receive data stream, and idle flags from the local transmit and receive paths. When the received signal is strong enough and carries frequent transitions, the block declares link pass. It drives a link-OK output that gates the transmit data, the receiver and the loopback path, and an active-low link LED.

All analog timing is done with counters. The level flag is debounced asymmetrically: it must be high for a rise window before it counts, and low for twice that window before it is dropped. A transition watchdog declares the input dead when the data holds still for too long. On leaving low-light, the block first requires a long qualification period of continuously valid signal. After that, it waits until both the transmit side and the receive side are idle before it enters link pass. Any loss of the valid signal during qualification or during the idle wait sends the block back to the start of the qualification.

Top module: `lli_link_monitor`

## Requirements
- R1: After reset, link_ok_o is 0 and link_led_no is 1 (low-light).
- R2: link_led_no is low exactly when link_ok_o is high.
- R3: In link pass, if rx_data_i holds its value longer than GAP_CYC cycles, link_ok_o falls. When the last change of rx_data_i is driven before clock edge 1, link_ok_o is low after edge GAP_CYC+2.
- R4: In link pass, level_ok_i low for fewer than 2*RISE_CYC consecutive cycles leaves link_ok_o at 1. Low for 2*RISE_CYC consecutive cycles makes link_ok_o fall after edge 2*RISE_CYC+1, counted from the first low sample.
- R5: level_ok_i counts as valid only after it has been high for RISE_CYC consecutive cycles. The drop-out window is twice this rise window.
- R6: Leaving low-light needs QUAL_CYC consecutive cycles of valid signal (level valid and transitions at most GAP_CYC cycles apart). From reset, with level high, rx_data_i toggling every cycle and both idles high, link_ok_o rises after edge RISE_CYC+QUAL_CYC+1.
- R7: After qualification, link pass is entered only on an edge where both tx_idle_i and rx_idle_i are 1. Until then, link_ok_o stays 0. Once both are 1, link_ok_o rises after the next edge.
- R8: A loss of valid signal during qualification or during the idle wait restarts the full qualification period.
- R9: link_ok_o is 0 in every state other than link pass, including the qualification and the idle wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| level_ok_i | input | 1 | Received level above threshold |
| rx_data_i | input | 1 | Sliced receive data, synchronous to clk_i |
| tx_idle_i | input | 1 | Transmit input is idle |
| rx_idle_i | input | 1 | No receive data in progress |
| link_ok_o | output | 1 | Link pass: enables transmit data, receiver and loopback |
| link_led_no | output | 1 | Link LED, active low |

## Verification
The bench builds the block with GAP_CYC=6, RISE_CYC=4 and QUAL_CYC=20, instead of the millisecond-scale defaults. With these values, one run can cover many full qualifications, rise and drop-out debounces, and transition time-outs. The same short windows let random level dips and data gaps land on both sides of every counter limit. They also bring qualification restarts and long idle waits into a few thousand cycles.

// File: rtl/lli_pkg.sv
package lli_pkg;
  typedef enum logic [1:0] {
    ST_LOW  = 2'd0,
    ST_WAIT = 2'd1,
    ST_PASS = 2'd2
  } link_st_e;
endpackage

// File: rtl/lli_activity.sv
module lli_activity #(
  parameter int unsigned GAP_CYC = 60
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_data_i,
  output logic active_o
);
  localparam int unsigned GW = $clog2(GAP_CYC + 1);
  localparam logic [GW-1:0] GAP_LIM = GW'(GAP_CYC);

  logic          prev_q;
  logic [GW-1:0] gap_q;
  logic          edge_seen;

  assign edge_seen = rx_data_i ^ prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      gap_q  <= GAP_LIM;
    end else begin
      prev_q <= rx_data_i;
      if (edge_seen)             gap_q <= '0;
      else if (gap_q != GAP_LIM) gap_q <= gap_q + 1'b1;
    end
  end

  assign active_o = (gap_q != GAP_LIM);
endmodule

// File: rtl/lli_level_filter.sv
module lli_level_filter #(
  parameter int unsigned RISE_CYC = 60
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  output logic level_o
);
  localparam int unsigned FALL_CYC = 2 * RISE_CYC;
  localparam int unsigned CW = $clog2(FALL_CYC + 1);
  localparam logic [CW-1:0] RISE_LAST = CW'(RISE_CYC - 1);
  localparam logic [CW-1:0] FALL_LAST = CW'(FALL_CYC - 1);

  logic          lvl_q;
  logic [CW-1:0] cnt_q;
  logic          against;
  logic [CW-1:0] last;

  // input disagrees with the filtered level
  assign against = level_i ^ lvl_q;
  assign last    = lvl_q ? FALL_LAST : RISE_LAST;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else if (!against) begin
      cnt_q <= '0;
    end else if (cnt_q == last) begin
      lvl_q <= level_i;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign level_o = lvl_q;
endmodule

// File: rtl/lli_fsm.sv
module lli_fsm
  import lli_pkg::*;
#(
  parameter int unsigned QUAL_CYC = 10_000_000
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     valid_i,
  input  logic     tx_idle_i,
  input  logic     rx_idle_i,
  output link_st_e state_o
);
  localparam int unsigned QW = $clog2(QUAL_CYC + 1);
  localparam logic [QW-1:0] Q_LAST = QW'(QUAL_CYC - 1);

  link_st_e      st_q, st_d;
  logic [QW-1:0] q_q, q_d;

  always_comb begin
    st_d = st_q;
    q_d  = q_q;
    unique case (st_q)
      ST_LOW: begin
        if (!valid_i)          q_d = '0;
        else if (q_q == Q_LAST) begin
          st_d = ST_WAIT;
          q_d  = '0;
        end else               q_d = q_q + 1'b1;
      end
      ST_WAIT: begin
        if (!valid_i)                    st_d = ST_LOW;
        else if (tx_idle_i && rx_idle_i) st_d = ST_PASS;
      end
      ST_PASS: begin
        if (!valid_i) st_d = ST_LOW;
      end
      default: begin
        st_d = ST_LOW;
        q_d  = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_LOW;
      q_q  <= '0;
    end else begin
      st_q <= st_d;
      q_q  <= q_d;
    end
  end

  assign state_o = st_q;
endmodule

// File: rtl/lli_link_monitor.sv
module lli_link_monitor
  import lli_pkg::*;
#(
  parameter int unsigned GAP_CYC  = 60,
  parameter int unsigned RISE_CYC = 60,
  parameter int unsigned QUAL_CYC = 10_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_ok_i,
  input  logic rx_data_i,
  input  logic tx_idle_i,
  input  logic rx_idle_i,
  output logic link_ok_o,
  output logic link_led_no
);
  logic     act_ok;
  logic     lvl_ok;
  logic     sig_valid;
  link_st_e state;

  lli_activity #(.GAP_CYC(GAP_CYC)) u_act (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rx_data_i(rx_data_i),
    .active_o (act_ok)
  );

  lli_level_filter #(.RISE_CYC(RISE_CYC)) u_lvl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .level_i(level_ok_i),
    .level_o(lvl_ok)
  );

  assign sig_valid = lvl_ok & act_ok;

  lli_fsm #(.QUAL_CYC(QUAL_CYC)) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (sig_valid),
    .tx_idle_i(tx_idle_i),
    .rx_idle_i(rx_idle_i),
    .state_o  (state)
  );

  assign link_ok_o   = (state == ST_PASS);
  assign link_led_no = ~link_ok_o;
endmodule

// File: rtl/lli_checker.sv
module lli_checker #(
  parameter int unsigned QUAL_CYC = 10_000_000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic level_ok_i,
  input logic tx_idle_i,
  input logic rx_idle_i,
  input logic link_ok_o,
  input logic lvl_ok,
  input logic sig_valid
);
  localparam int unsigned QW = $clog2(QUAL_CYC + 2);
  localparam logic [QW-1:0] Q_SAT = QW'(QUAL_CYC);

  logic [QW-1:0] run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              run_q <= '0;
    else if (!sig_valid)      run_q <= '0;
    else if (run_q != Q_SAT)  run_q <= run_q + 1'b1;
  end

  p_drop_on_invalid_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_ok_o && !sig_valid) |=> !link_ok_o);

  p_entry_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(link_ok_o) |-> $past(tx_idle_i && rx_idle_i));

  p_entry_qualified_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(link_ok_o) |-> (run_q == Q_SAT));

  p_level_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lvl_ok) |-> $past(level_ok_i));

  p_level_fall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lvl_ok) |-> !$past(level_ok_i));
endmodule

bind lli_link_monitor lli_checker #(.QUAL_CYC(QUAL_CYC)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .level_ok_i(level_ok_i),
  .tx_idle_i (tx_idle_i),
  .rx_idle_i (rx_idle_i),
  .link_ok_o (link_ok_o),
  .lvl_ok    (lvl_ok),
  .sig_valid (sig_valid)
);

// File: tb/lli_link_monitor_test.sv
`timescale 1ns/1ps
module lli_link_monitor_test;
  localparam int GAP  = 6;
  localparam int RISE = 4;
  localparam int FALL = 2 * RISE;
  localparam int QUAL = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic level_ok = 1'b0, rx_data = 1'b0, tx_idle = 1'b1, rx_idle = 1'b1;
  logic link_ok, led_n;

  lli_link_monitor #(.GAP_CYC(GAP), .RISE_CYC(RISE), .QUAL_CYC(QUAL)) uut (
    .clk_i(clk), .rst_ni(rst_n), .level_ok_i(level_ok), .rx_data_i(rx_data),
    .tx_idle_i(tx_idle), .rx_idle_i(rx_idle), .link_ok_o(link_ok), .link_led_no(led_n)
  );

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // stimulus knobs applied by cyc()
  bit lvl_v = 0, tog_v = 0, txi_v = 1, rxi_v = 1;

  // reference model, built from the requirements
  bit m_prev, m_lvl;
  int m_gap, m_lc, m_st, m_q;

  function automatic bit model_ok();
    return m_st == 2;
  endfunction

  always @(posedge clk) begin
    bit valid, edg;
    if (!rst_n) begin
      m_prev = 0; m_gap = GAP; m_lvl = 0; m_lc = 0; m_st = 0; m_q = 0;
    end else begin
      edg   = (rx_data != m_prev);
      valid = m_lvl && (m_gap < GAP);
      case (m_st)
        0: if (!valid) m_q = 0;
           else if (m_q == QUAL - 1) begin m_st = 1; m_q = 0; end
           else m_q++;
        1: if (!valid) m_st = 0; else if (tx_idle && rx_idle) m_st = 2;
        default: if (!valid) m_st = 0;
      endcase
      if (level_ok != m_lvl) begin
        if (m_lc == (m_lvl ? FALL : RISE) - 1) begin m_lvl = level_ok; m_lc = 0; end
        else m_lc++;
      end else m_lc = 0;
      if (edg) m_gap = 0; else if (m_gap < GAP) m_gap++;
      m_prev = rx_data;
    end
  end

  task automatic check(input bit cond, input string tag, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // drive at a falling edge, let one rising edge pass, sample at the next falling edge
  task automatic cyc();
    level_ok = lvl_v; tx_idle = txi_v; rx_idle = rxi_v;
    if (tog_v) rx_data = ~rx_data;
    @(negedge clk);
    check(link_ok == model_ok(), "R9 model link_ok", link_ok, model_ok());
    check(led_n == !link_ok, "R2 led polarity", led_n, !link_ok);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic wait_rise(output int n);
    n = 0;
    do begin cyc(); n++; end while (!link_ok && n < 200);
  endtask

  task automatic wait_fall(output int n);
    n = 0;
    do begin cyc(); n++; end while (link_ok && n < 200);
  endtask

  initial begin
    int n;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(link_ok == 0, "R1 reset link_ok", link_ok, 0);
    check(led_n == 1, "R1 reset led", led_n, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(link_ok == 0 && led_n == 1, "R1 after release", link_ok, 0);

    // R6 bring-up latency
    lvl_v = 1; tog_v = 1; txi_v = 1; rxi_v = 1;
    wait_rise(n);
    check(n == RISE + QUAL + 1, "R6 bring-up cycles", n, RISE + QUAL + 1);
    check(led_n == 0, "R2 led on in pass", led_n, 0);

    // R4 short dip ignored
    lvl_v = 0; run(FALL - 1);
    check(link_ok == 1, "R4 short dip", link_ok, 1);
    lvl_v = 1; run(3);
    check(link_ok == 1, "R4 after dip", link_ok, 1);

    // R4 / R5 full drop-out window
    lvl_v = 0;
    wait_fall(n);
    check(n == FALL + 1, "R4 drop latency", n, FALL + 1);

    // R7 hold in wait while tx busy
    lvl_v = 1; txi_v = 0;
    run(RISE + QUAL + 15);
    check(link_ok == 0, "R7 tx busy blocks", link_ok, 0);
    txi_v = 1; rxi_v = 0; run(5);
    check(link_ok == 0, "R7 rx busy blocks", link_ok, 0);
    rxi_v = 1; run(1);
    check(link_ok == 1, "R7 entry on idle", link_ok, 1);

    // R3 transition gap
    tog_v = 1; cyc(); tog_v = 0;
    n = 1;
    while (link_ok && n < 100) begin cyc(); n++; end
    check(n == GAP + 2, "R3 gap drop latency", n, GAP + 2);

    // R8 restart during qualification
    tog_v = 1; run(10);
    tog_v = 0; run(GAP + 1);
    tog_v = 1; run(QUAL + 1 - 10);
    check(link_ok == 0, "R8 restart holds low", link_ok, 0);
    check(led_n == 1, "R9 led off while qualifying", led_n, 1);
    wait_rise(n);
    check(link_ok == 1, "R8 recovers after full wait", link_ok, 1);

    // R5 level must be high RISE cycles before qualifying
    lvl_v = 0; run(FALL + 2);
    lvl_v = 1; run(RISE - 1);
    lvl_v = 0; run(1);
    lvl_v = 1; run(QUAL + RISE - 1);
    check(link_ok == 0, "R5 rise window restarts", link_ok, 0);

    // random phase against the model
    for (int seg = 0; seg < 120; seg++) begin
      int pl, pt, pi;
      case ($urandom % 3)
        0: pl = 100; 1: pl = 97; default: pl = 60;
      endcase
      case ($urandom % 3)
        0: pt = 90; 1: pt = 55; default: pt = 25;
      endcase
      pi = 60 + ($urandom % 40);
      for (int k = 0; k < 200; k++) begin
        lvl_v = (($urandom % 100) < pl);
        tog_v = (($urandom % 100) < pt);
        txi_v = (($urandom % 100) < pi);
        rxi_v = (($urandom % 100) < pi);
        cyc();
      end
    end

    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule